// File: doc/BRIEF.md
# Programmable UART Character Transmitter

This block turns characters into asynchronous serial frames on one transmit line. Characters enter through a valid/ready handshake into a small FIFO. A sequencer then sends each one as a start bit, 5 to 14 data bits, an optional parity bit and one or two stop bits. Bit timing comes from an external baud tick: the line moves to its next bit only on a clock edge where the tick is high.

The transmitter never leaves gaps between characters. When the FIFO is empty and the block is enabled, it sends idle-fill frames: one character time of ones at the current format. Two request inputs insert special frames at the next character boundary. A break is one character time of zeros with no stop bit. A preamble is one character time of ones. Break takes precedence over preamble, and preamble takes precedence over queued data.

Format settings are captured when each frame starts. Changing them while a frame is on the line only affects later frames.

Top module: `uart_char_tx`

## Requirements
- R1: After reset, `txd_o` is 1, `busy_o` is 0, `char_done_o` is 0 and `ready_o` is 1.
- R2: A data frame is a start bit of 0, then the data bits LSB first, then the stop bits at 1. The data length is `char_len_i`, clamped so that values below 5 act as 5 and values above 14 act as 14.
- R3: With `two_stop_i` = 1 the frame ends with two stop bits; with 0 it ends with one.
- R4: `parity_i` = 01 appends an even parity bit after the data and 10 appends an odd parity bit. Values 00 and 11 send no parity bit.
- R5: `txd_o` changes only on a clock edge where `baud_tick_i` is high, so each bit lasts one tick period.
- R6: While enabled with nothing queued or requested, the line stays at 1 with `busy_o` low and no `char_done_o`.
- R7: A queued character starts, with its start bit, on the very tick that ends the previous frame. There is no idle bit between frames.
- R8: A break request produces one character time (the frame length at the current format) of 0 after the current frame. `busy_o` is high during it, and it ends with `char_done_o`.
- R9: A preamble request produces one character time of 1 with `busy_o` high, and it ends with `char_done_o`.
- R10: Requests take effect only at a frame boundary. A frame in progress completes unchanged. At a boundary a break goes first, then a preamble, then queued data.
- R11: `char_done_o` is high for exactly one clock, in the cycle after the tick edge that ends a data, break or preamble frame. `busy_o` stays high from the frame's start through its last bit.
- R12: The FIFO holds `FIFO_DEPTH` (4) characters. `ready_o` is low when it is full, a push while full is dropped, and characters leave in arrival order.
- R13: Length, stop count and parity are latched when a frame starts. Changes during the frame do not alter it.
- R14: With `en_i` low, no new frame starts at a boundary. The line holds 1 and queued characters stay in the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Transmitter enable, sampled at frame boundaries |
| baud_tick_i | input | 1 | One-cycle bit-rate strobe |
| char_len_i | input | 4 | Data bits per character (5..14, clamped) |
| two_stop_i | input | 1 | 1 selects two stop bits |
| parity_i | input | 2 | 00/11 none, 01 even, 10 odd |
| break_req_i | input | 1 | Request a break frame |
| preamble_req_i | input | 1 | Request a preamble frame |
| data_i | input | 14 | Character to queue |
| valid_i | input | 1 | `data_i` is offered |
| ready_o | output | 1 | FIFO can accept a character |
| txd_o | output | 1 | Serial transmit line |
| busy_o | output | 1 | A data, break or preamble frame is on the line |
| char_done_o | output | 1 | One-cycle pulse at the end of a non-idle frame |

## Verification
Every line change occurs on the clock edge where the tick is high. The bench raises the tick for one cycle and samples the line, `busy_o` and `char_done_o` at the falling edge just after that edge, which is where each new bit and the done pulse first appear. One cycle later it samples again, to confirm that the line held its value and that the done pulse has already dropped. `ready_o` is read at the falling edge before the push edge. This shows whether the push is accepted, and the effect of a dropped push appears later in the order and count of frames on the line. Break and preamble requests are raised between ticks, and their frames are expected at the next boundary tick and no earlier.

// File: rtl/uart_char_tx_pkg.sv
package uart_char_tx_pkg;

  localparam int unsigned LEN_MIN = 5;

  typedef enum logic [1:0] {
    FK_FILL = 2'd0,
    FK_DATA = 2'd1,
    FK_PRE  = 2'd2,
    FK_BRK  = 2'd3
  } frame_kind_e;

  localparam logic [1:0] PAR_EVEN = 2'b01;
  localparam logic [1:0] PAR_ODD  = 2'b10;

endpackage

// File: rtl/uart_char_tx_fifo.sv
module uart_char_tx_fifo #(
  parameter int unsigned W     = 14,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [CW-1:0] fill_o
);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) begin
        mem_q[wr_q] <= data_i;
        wr_q        <= bump(wr_q);
      end
      if (pop_i) rd_q <= bump(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o  = mem_q[rd_q];
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign fill_o  = cnt_q;

endmodule

// File: rtl/uart_char_tx_frame.sv
module uart_char_tx_frame
  import uart_char_tx_pkg::*;
#(
  parameter int unsigned DW = 14,
  localparam int unsigned FW = DW + 4,
  localparam int unsigned CW = $clog2(FW + 1),
  localparam int unsigned LW = $clog2(DW + 1)
) (
  input  frame_kind_e   kind_i,
  input  logic [DW-1:0] data_i,
  input  logic [LW-1:0] len_i,
  input  logic          two_stop_i,
  input  logic [1:0]    par_i,
  output logic [FW-1:0] frame_o,
  output logic [CW-1:0] nbits_o
);

  int          len_c;
  int          n_bits;
  logic        has_par;
  logic        par_bit;
  logic [FW-1:0] data_frame;

  always_comb begin
    len_c = int'(len_i);
    if (len_c < int'(LEN_MIN)) len_c = int'(LEN_MIN);
    else if (len_c > int'(DW)) len_c = int'(DW);

    has_par = (par_i == PAR_EVEN) || (par_i == PAR_ODD);
    par_bit = (par_i == PAR_ODD);
    for (int i = 0; i < int'(DW); i++)
      if (i < len_c) par_bit = par_bit ^ data_i[i];

    n_bits = 1 + len_c + (has_par ? 1 : 0) + (two_stop_i ? 2 : 1);

    // bit 0 is start, stop positions stay at 1
    data_frame    = '1;
    data_frame[0] = 1'b0;
    for (int i = 0; i < int'(DW); i++)
      if (i < len_c) data_frame[i+1] = data_i[i];
    for (int i = 0; i < int'(FW); i++)
      if (has_par && (i == len_c + 1)) data_frame[i] = par_bit;

    case (kind_i)
      FK_DATA: frame_o = data_frame;
      FK_BRK:  frame_o = '0;
      default: frame_o = '1;
    endcase
    nbits_o = CW'(n_bits);
  end

endmodule

// File: rtl/uart_char_tx_seq.sv
module uart_char_tx_seq
  import uart_char_tx_pkg::*;
#(
  parameter int unsigned FW = 18,
  localparam int unsigned CW = $clog2(FW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          baud_tick_i,
  input  logic          brk_req_i,
  input  logic          pre_req_i,
  input  logic          have_data_i,
  input  logic [FW-1:0] frame_i,
  input  logic [CW-1:0] nbits_i,
  output frame_kind_e   sel_kind_o,
  output logic          pop_o,
  output logic          txd_o,
  output logic          busy_o,
  output logic          done_o,
  output frame_kind_e   kind_o
);

  logic          run_q;
  logic [CW-1:0] cnt_q;
  logic [FW-1:0] shift_q;
  logic          txd_q, done_q;
  logic          pend_brk_q, pend_pre_q;
  frame_kind_e   kind_q, sel_kind;
  logic          brk_any, pre_any, boundary, load;

  assign brk_any = pend_brk_q | brk_req_i;
  assign pre_any = pend_pre_q | pre_req_i;

  always_comb begin
    if (brk_any)          sel_kind = FK_BRK;
    else if (pre_any)     sel_kind = FK_PRE;
    else if (have_data_i) sel_kind = FK_DATA;
    else                  sel_kind = FK_FILL;
  end

  // boundary: tick that closes the last bit, or any tick while stopped
  assign boundary = baud_tick_i && (!run_q || (cnt_q == '0));
  assign load     = boundary && en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q      <= 1'b0;
      cnt_q      <= '0;
      shift_q    <= '1;
      txd_q      <= 1'b1;
      kind_q     <= FK_FILL;
      done_q     <= 1'b0;
      pend_brk_q <= 1'b0;
      pend_pre_q <= 1'b0;
    end else begin
      done_q     <= boundary && run_q && (kind_q != FK_FILL);
      pend_brk_q <= brk_any && !(load && (sel_kind == FK_BRK));
      pend_pre_q <= pre_any && !(load && (sel_kind == FK_PRE));
      if (load) begin
        txd_q   <= frame_i[0];
        shift_q <= {1'b1, frame_i[FW-1:1]};
        cnt_q   <= nbits_i - CW'(1);
        kind_q  <= sel_kind;
        run_q   <= 1'b1;
      end else if (boundary) begin
        txd_q  <= 1'b1;
        cnt_q  <= '0;
        kind_q <= FK_FILL;
        run_q  <= 1'b0;
      end else if (baud_tick_i) begin
        txd_q   <= shift_q[0];
        shift_q <= {1'b1, shift_q[FW-1:1]};
        cnt_q   <= cnt_q - CW'(1);
      end
    end
  end

  assign sel_kind_o = sel_kind;
  assign pop_o      = load && (sel_kind == FK_DATA);
  assign txd_o      = txd_q;
  assign busy_o     = run_q && (kind_q != FK_FILL);
  assign done_o     = done_q;
  assign kind_o     = kind_q;

endmodule

// File: rtl/uart_char_tx.sv
module uart_char_tx
  import uart_char_tx_pkg::*;
#(
  parameter int unsigned DATA_W     = 14,
  parameter int unsigned FIFO_DEPTH = 4,
  localparam int unsigned FW  = DATA_W + 4,
  localparam int unsigned CW  = $clog2(FW + 1),
  localparam int unsigned LW  = $clog2(DATA_W + 1),
  localparam int unsigned FCW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              baud_tick_i,
  input  logic [LW-1:0]     char_len_i,
  input  logic              two_stop_i,
  input  logic [1:0]        parity_i,
  input  logic              break_req_i,
  input  logic              preamble_req_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              txd_o,
  output logic              busy_o,
  output logic              char_done_o
);

  logic [DATA_W-1:0] head_w;
  logic              full_w, empty_w, pop_w, push_w;
  logic [FCW-1:0]    fill_w;
  logic [FW-1:0]     frame_w;
  logic [CW-1:0]     nbits_w;
  frame_kind_e       sel_kind_w, kind_q_w;
  logic [1:0]        kind_w;

  assign push_w  = valid_i && !full_w;
  assign ready_o = !full_w;
  assign kind_w  = kind_q_w;

  uart_char_tx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push_w),
    .data_i  (data_i),
    .pop_i   (pop_w),
    .head_o  (head_w),
    .full_o  (full_w),
    .empty_o (empty_w),
    .fill_o  (fill_w)
  );

  uart_char_tx_frame #(.DW(DATA_W)) frame_i (
    .kind_i     (sel_kind_w),
    .data_i     (head_w),
    .len_i      (char_len_i),
    .two_stop_i (two_stop_i),
    .par_i      (parity_i),
    .frame_o    (frame_w),
    .nbits_o    (nbits_w)
  );

  uart_char_tx_seq #(.FW(FW)) seq_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .baud_tick_i (baud_tick_i),
    .brk_req_i   (break_req_i),
    .pre_req_i   (preamble_req_i),
    .have_data_i (!empty_w),
    .frame_i     (frame_w),
    .nbits_i     (nbits_w),
    .sel_kind_o  (sel_kind_w),
    .pop_o       (pop_w),
    .txd_o       (txd_o),
    .busy_o      (busy_o),
    .done_o      (char_done_o),
    .kind_o      (kind_q_w)
  );

endmodule

// File: rtl/uart_char_tx_chk.sv
module uart_char_tx_chk
  import uart_char_tx_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned FCW   = 3
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           baud_tick_i,
  input logic           valid_i,
  input logic           ready_o,
  input logic           txd_o,
  input logic           busy_o,
  input logic           char_done_o,
  input logic [1:0]     kind_i,
  input logic           pop_i,
  input logic [FCW-1:0] fill_i
);

  p_line_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !baud_tick_i |=> $stable(txd_o));

  p_done_on_tick_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_done_o |-> $past(baud_tick_i));

  p_done_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_done_o |=> !char_done_o);

  p_idle_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> txd_o);

  p_break_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && (kind_i == FK_BRK)) |-> !txd_o);

  p_preamble_high_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && (kind_i == FK_PRE)) |-> txd_o);

  p_full_drop_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !ready_o && !pop_i) |=> (fill_i == $past(fill_i)));

  p_ready_room_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (fill_i < FCW'(DEPTH)));

endmodule

bind uart_char_tx uart_char_tx_chk #(.DEPTH(FIFO_DEPTH), .FCW(FCW)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .baud_tick_i (baud_tick_i),
  .valid_i     (valid_i),
  .ready_o     (ready_o),
  .txd_o       (txd_o),
  .busy_o      (busy_o),
  .char_done_o (char_done_o),
  .kind_i      (kind_w),
  .pop_i       (pop_w),
  .fill_i      (fill_w)
);

// File: tb/uart_char_tx_tb_top.sv
module uart_char_tx_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b1;
  logic        baud_tick_i = 1'b0;
  logic [3:0]  char_len_i = 4'd8;
  logic        two_stop_i = 1'b0;
  logic [1:0]  parity_i = 2'b00;
  logic        break_req_i = 1'b0;
  logic        preamble_req_i = 1'b0;
  logic [13:0] data_i = '0;
  logic        valid_i = 1'b0;
  logic        ready_o, txd_o, busy_o, char_done_o;

  int checks = 0;
  int fails  = 0;

  logic line_bit = 1'b1;
  logic last_done = 1'b0;
  logic last_busy = 1'b0;
  int   hold_err = 0;
  int   pulse_err = 0;

  always #10 clk_i = ~clk_i;

  uart_char_tx dut_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .en_i           (en_i),
    .baud_tick_i    (baud_tick_i),
    .char_len_i     (char_len_i),
    .two_stop_i     (two_stop_i),
    .parity_i       (parity_i),
    .break_req_i    (break_req_i),
    .preamble_req_i (preamble_req_i),
    .data_i         (data_i),
    .valid_i        (valid_i),
    .ready_o        (ready_o),
    .txd_o          (txd_o),
    .busy_o         (busy_o),
    .char_done_o    (char_done_o)
  );

  // {len[20:17], two_stop[16], parity[15:14], data[13:0]}
  localparam int NV = 8;
  localparam logic [20:0] VEC [NV] = '{
    {4'd8,  1'b0, 2'b00, 14'h0055},
    {4'd5,  1'b0, 2'b01, 14'h0013},
    {4'd14, 1'b1, 2'b10, 14'h2A5B},
    {4'd7,  1'b1, 2'b01, 14'h007F},
    {4'd9,  1'b0, 2'b10, 14'h0100},
    {4'd3,  1'b0, 2'b00, 14'h001F},
    {4'd15, 1'b0, 2'b01, 14'h3FFF},
    {4'd6,  1'b1, 2'b11, 14'h002A}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int clamp_len(input int l);
    if (l < 5) return 5;
    if (l > 14) return 14;
    return l;
  endfunction

  function automatic int frame_len(input int len, input bit two, input logic [1:0] par);
    return 1 + clamp_len(len) + ((par == 2'b01 || par == 2'b10) ? 1 : 0) + (two ? 2 : 1);
  endfunction

  function automatic logic [17:0] exp_frame(input int len, input bit two,
                                            input logic [1:0] par, input logic [13:0] d);
    logic [17:0] b;
    int   l;
    logic p;
    l = clamp_len(len);
    b = '1;
    b[0] = 1'b0;
    p = (par == 2'b10);
    for (int i = 0; i < l; i++) begin
      b[1+i] = d[i];
      p = p ^ d[i];
    end
    if (par == 2'b01 || par == 2'b10) b[1+l] = p;
    return b;
  endfunction

  // one baud tick; samples the bit launched by it, then checks hold and pulse width
  task automatic tick();
    @(negedge clk_i) baud_tick_i = 1'b1;
    @(negedge clk_i) baud_tick_i = 1'b0;
    line_bit  = txd_o;
    last_done = char_done_o;
    last_busy = busy_o;
    @(negedge clk_i);
    if (txd_o !== line_bit) hold_err++;
    if (char_done_o !== 1'b0) pulse_err++;
  endtask

  task automatic push(input logic [13:0] d, output bit acc);
    @(negedge clk_i);
    data_i  = d;
    valid_i = 1'b1;
    acc     = ready_o;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic hunt_start(input string req);
    int k = 0;
    while (line_bit !== 1'b0 && k < 80) begin
      tick();
      k++;
    end
    chk(line_bit === 1'b0, req, "start bit found", int'(line_bit), 0);
  endtask

  // receive bits 1..n-1 of an expected frame, then the boundary tick
  task automatic recv_rest(input logic [17:0] exp, input int n, input string req);
    int mism = 0;
    int bbad = 0;
    int dbad = 0;
    for (int i = 1; i < n; i++) begin
      tick();
      if (line_bit !== exp[i]) mism++;
      if (last_busy !== 1'b1) bbad++;
      if (last_done !== 1'b0) dbad++;
    end
    chk(mism == 0, req, "frame bits mismatched", mism, 0);
    chk(bbad == 0 && dbad == 0, "R11", "busy low or early done inside frame", bbad + dbad, 0);
    tick();
    chk(last_done === 1'b1, "R11", "done after last bit", int'(last_done), 1);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog expired: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    bit acc;
    int n;
    int bad;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(txd_o === 1'b1, "R1", "txd at reset", int'(txd_o), 1);
    chk(busy_o === 1'b0, "R1", "busy at reset", int'(busy_o), 0);
    chk(char_done_o === 1'b0, "R1", "done at reset", int'(char_done_o), 0);
    chk(ready_o === 1'b1, "R1", "ready at reset", int'(ready_o), 1);
    rst_ni = 1'b1;

    // R6 idle fill
    bad = 0;
    for (int i = 0; i < 30; i++) begin
      tick();
      if (line_bit !== 1'b1 || last_busy !== 1'b0 || last_done !== 1'b0) bad++;
    end
    chk(bad == 0, "R6", "idle fill ticks not idle", bad, 0);

    // R2 R3 R4 vector table
    for (int v = 0; v < NV; v++) begin
      char_len_i = VEC[v][20:17];
      two_stop_i = VEC[v][16];
      parity_i   = VEC[v][15:14];
      push(VEC[v][13:0], acc);
      hunt_start("R2");
      n = frame_len(int'(VEC[v][20:17]), VEC[v][16], VEC[v][15:14]);
      recv_rest(exp_frame(int'(VEC[v][20:17]), VEC[v][16], VEC[v][15:14], VEC[v][13:0]),
                n, "R2 R3 R4");
      chk(line_bit === 1'b1 && last_busy === 1'b0, "R6", "line idle after frame",
          int'(line_bit), 1);
    end

    // R7 back-to-back
    char_len_i = 4'd8; two_stop_i = 1'b0; parity_i = 2'b00;
    push(14'h0A5, acc);
    push(14'h03C, acc);
    hunt_start("R7");
    recv_rest(exp_frame(8, 0, 2'b00, 14'h0A5), 10, "R7");
    chk(line_bit === 1'b0 && last_busy === 1'b1, "R7", "next start on boundary tick",
        int'(line_bit), 0);
    recv_rest(exp_frame(8, 0, 2'b00, 14'h03C), 10, "R7");

    // R13 config latched at frame start
    push(14'h0C3, acc);
    hunt_start("R13");
    tick(); tick();
    char_len_i = 4'd5; parity_i = 2'b10; two_stop_i = 1'b1;
    begin : r13_rest
      logic [17:0] e;
      int mism = 0;
      e = exp_frame(8, 0, 2'b00, 14'h0C3);
      for (int i = 3; i < 10; i++) begin
        tick();
        if (line_bit !== e[i]) mism++;
      end
      chk(mism == 0, "R13", "frame altered by mid-frame config", mism, 0);
      tick();
      chk(last_done === 1'b1, "R13", "frame length kept at 10", int'(last_done), 1);
    end
    char_len_i = 4'd8; parity_i = 2'b00; two_stop_i = 1'b0;
    repeat (12) tick();

    // R8 R10 break requested mid-frame
    push(14'h0F0, acc);
    hunt_start("R10");
    tick(); tick(); tick();
    @(negedge clk_i) break_req_i = 1'b1;
    @(negedge clk_i) break_req_i = 1'b0;
    begin : r10_rest
      logic [17:0] e;
      int mism = 0;
      e = exp_frame(8, 0, 2'b00, 14'h0F0);
      for (int i = 4; i < 10; i++) begin
        tick();
        if (line_bit !== e[i]) mism++;
      end
      chk(mism == 0, "R10", "data frame cut by break", mism, 0);
      tick();
      chk(last_done === 1'b1, "R10", "data frame done", int'(last_done), 1);
    end
    chk(line_bit === 1'b0 && last_busy === 1'b1, "R8", "break starts at boundary",
        int'(line_bit), 0);
    recv_rest(18'h0, 10, "R8");
    chk(line_bit === 1'b1 && last_busy === 1'b0, "R8", "line idle after break",
        int'(line_bit), 1);

    // R9 R10 priority: break, then preamble, then data
    push(14'h033, acc);
    @(negedge clk_i) begin break_req_i = 1'b1; preamble_req_i = 1'b1; end
    @(negedge clk_i) begin break_req_i = 1'b0; preamble_req_i = 1'b0; end
    hunt_start("R10");
    recv_rest(18'h0, 10, "R10");
    chk(line_bit === 1'b1 && last_busy === 1'b1, "R9", "preamble follows break",
        int'(last_busy), 1);
    recv_rest(18'h3FFFF, 10, "R9");
    chk(line_bit === 1'b0, "R10", "data after preamble", int'(line_bit), 0);
    recv_rest(exp_frame(8, 0, 2'b00, 14'h033), 10, "R10");

    // R12 R14 disabled queue fill
    en_i = 1'b0;
    repeat (12) tick();
    for (int i = 0; i < 4; i++) begin
      push(14'(16 + i), acc);
      chk(acc == 1'b1, "R12", "push accepted with room", int'(acc), 1);
    end
    push(14'h3AA, acc);
    chk(acc == 1'b0 && ready_o === 1'b0, "R12", "push refused when full", int'(acc), 0);
    bad = 0;
    for (int i = 0; i < 15; i++) begin
      tick();
      if (line_bit !== 1'b1 || last_busy !== 1'b0) bad++;
    end
    chk(bad == 0, "R14", "frame sent while disabled", bad, 0);
    chk(ready_o === 1'b0, "R14", "queue kept while disabled", int'(ready_o), 0);
    en_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      hunt_start("R12");
      recv_rest(exp_frame(8, 0, 2'b00, 14'(16 + i)), 10, "R12");
    end
    bad = 0;
    for (int i = 0; i < 15; i++) begin
      tick();
      if (line_bit !== 1'b1) bad++;
    end
    chk(bad == 0, "R12", "dropped push appeared on line", bad, 0);

    chk(hold_err == 0, "R5", "line moved without tick", hold_err, 0);
    chk(pulse_err == 0, "R11", "done wider than one cycle", pulse_err, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule